// File: doc/BRIEF.md
# Per-Hart Wired Interrupt Delivery Controller

This block sits behind the source-state logic of a wired interrupt domain and decides, for every hart, which interrupt that hart should take next. It holds one target word per source (destination hart and priority). For each hart it keeps a delivery enable, a force bit and a priority threshold. From the enable and pending flags that the surrounding logic supplies, it continuously picks the best qualifying source for each hart. It presents that choice as a top-interrupt value and drives one external interrupt line per hart.

Software reaches the block through a simple word bus. Reading a hart's claim address returns the current top-interrupt value, and in the same cycle emits a one-hot request that clears that source's pending flag. For level-triggered sources whose input is still asserted, it emits a matching request to set the flag again. Pending flags themselves are kept outside the block.

Top module: `dhc_top`

## Requirements
- R1: Target words are at byte address 0x3000 + 4*s for source s (1..NSRC). Bits 31:18 select the hart. Bits 7:0 hold the priority, masked to PRIO_W bits, and bits 7:PRIO_W read as zero. A masked priority of 0 is stored as 1. After reset every target word reads 0x00000001.
- R2: For each hart, the winner is the enabled, pending source whose target hart equals that hart and whose priority value is smallest. Equal priorities go to the lower source number.
- R3: A hart threshold of 0 excludes nothing. A nonzero threshold excludes every source whose priority is greater than or equal to it.
- R4: The top-interrupt value, at hart window offset 0x18, is (source << 16) | priority, and reads 0 when no source qualifies. Hart h's window starts at 0x4000 + 32*h. Read data appears on `bus_rdata` the cycle after `bus_rd`.
- R5: A read of window offset 0x1C (claim) returns the top-interrupt value. When that value is nonzero, the read also drives `pend_clr` one-hot for the winning source (bit s-1) during the read cycle. Otherwise `pend_clr` stays zero.
- R6: During a claim, `pend_set` carries the same bit as `pend_clr` only when the source's mode is level-high (6) with input 1, or level-low (7) with input 0. Any other mode (0 off, 1 delegated, 4 rising, 5 falling) leaves `pend_set` zero.
- R7: A claim read that finds no qualifying source clears that hart's force bit.
- R8: `irq_o[h]` is 1 exactly when, one clock edge earlier, `dom_en` was 1, the hart's delivery bit was 1, and either its force bit was set or its top-interrupt value was nonzero.
- R9: The delivery bit (offset 0x00) and force bit (offset 0x04) store only bit 0 of the written data. The threshold (offset 0x08) stores the low PRIO_W bits. All three read back zero-extended and reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dom_en | input | 1 | Domain-wide interrupt enable |
| src_en | input | NSRC | Enable flag per source, bit s-1 for source s |
| src_pend | input | NSRC | Pending flag per source |
| src_level | input | NSRC | Current input level per source |
| src_mode | input | 3*NSRC | Trigger mode per source, 3 bits each |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pend_clr | output | NSRC | Clear request for the claimed source |
| pend_set | output | NSRC | Re-pend request for a claimed active level source |
| irq_o | output | NHART | External interrupt line per hart |

## Verification
A corrupted target word or a bad comparison shows at the ports as a wrong top-interrupt or claim value. That wrong value appears on the read data one cycle after the read strobe. A wrong delivery, force or dom_en gate shows on irq_o one clock edge after the cause. A wrong claim decode shows in the same cycle as the read, as a clear pulse on the wrong source or a missing re-pend pulse. A force bit that survives an empty claim keeps irq_o high one edge longer than it should, and reads back as 1.

// File: rtl/dhc_pkg.sv
package dhc_pkg;

  typedef enum logic [2:0] {
    SM_OFF   = 3'd0,
    SM_DELEG = 3'd1,
    SM_RISE  = 3'd4,
    SM_FALL  = 3'd5,
    SM_HIGH  = 3'd6,
    SM_LOW   = 3'd7
  } smode_e;

  localparam int HIDX_W  = 14;
  localparam int HIDX_LO = 18;
  localparam int ID_W    = 10;

  // priority as stored: masked, with zero promoted to one
  function automatic logic [7:0] fix_prio(input logic [7:0] raw, input logic [7:0] mask);
    logic [7:0] m;
    m = raw & mask;
    return (m == 8'd0) ? 8'd1 : m;
  endfunction

  function automatic logic [31:0] pack_top(input logic [ID_W-1:0] id, input logic [7:0] pr);
    return {6'd0, id, 8'd0, pr};
  endfunction

  // level source whose input still requests service
  function automatic logic level_active(input logic [2:0] mode, input logic lvl);
    return (mode == SM_HIGH && lvl) || (mode == SM_LOW && !lvl);
  endfunction

endpackage

// File: rtl/dhc_targets.sv
module dhc_targets #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [9:0]         widx,
  input  logic [31:0]        wdata,
  output logic [NSRC*32-1:0] tgt_flat
);
  import dhc_pkg::*;
  localparam logic [7:0] PMASK = 8'((1 << PRIO_W) - 1);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [31:0] tw_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                         tw_q <= 32'h1;
      else if (we && widx == 10'(s + 1))  tw_q <= {wdata[31:8], fix_prio(wdata[7:0], PMASK)};
    end
    assign tgt_flat[s*32 +: 32] = tw_q;

    p_prio_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tw_q[7:0] & PMASK) != 8'd0);
  end
endmodule

// File: rtl/dhc_select.sv
module dhc_select #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 3,
  parameter int HART   = 0
) (
  input  logic [NSRC-1:0]        en,
  input  logic [NSRC-1:0]        pend,
  input  logic [NSRC*14-1:0]     hart_f,
  input  logic [NSRC*PRIO_W-1:0] prio_f,
  input  logic [PRIO_W-1:0]      thr,
  output logic [31:0]            top,
  output logic [9:0]             win_id
);
  import dhc_pkg::*;
  logic              found;
  logic [PRIO_W-1:0] best;

  always_comb begin
    found  = 1'b0;
    best   = '1;
    win_id = '0;
    for (int s = 0; s < NSRC; s++) begin
      logic [PRIO_W-1:0] pr;
      logic ok;
      pr = prio_f[s*PRIO_W +: PRIO_W];
      ok = en[s] && pend[s] && (hart_f[s*14 +: 14] == 14'(HART)) &&
           ((thr == '0) || (pr < thr));
      if (ok && (!found || pr < best)) begin
        found  = 1'b1;
        best   = pr;
        win_id = 10'(s + 1);
      end
    end
    top = found ? pack_top(win_id, 8'(best)) : 32'd0;
  end
endmodule

// File: rtl/dhc_hart_ctl.sv
module dhc_hart_ctl #(
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dom_en,
  input  logic              we_deliv,
  input  logic              we_force,
  input  logic              we_thr,
  input  logic [31:0]       wdata,
  input  logic              claim_empty,
  input  logic              top_nz,
  output logic              deliv_q,
  output logic              force_q,
  output logic [PRIO_W-1:0] thr_q,
  output logic              irq
);
  logic [31:PRIO_W] unused_hi;
  assign unused_hi = wdata[31:PRIO_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deliv_q <= 1'b0;
      force_q <= 1'b0;
      thr_q   <= '0;
      irq     <= 1'b0;
    end else begin
      if (we_deliv) deliv_q <= wdata[0];
      if (we_force) force_q <= wdata[0];
      else if (claim_empty) force_q <= 1'b0;
      if (we_thr) thr_q <= wdata[PRIO_W-1:0];
      irq <= dom_en && deliv_q && (force_q || top_nz);
    end
  end

  p_force_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_empty && !we_force) |=> !force_q);
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(dom_en && deliv_q));
endmodule

// File: rtl/dhc_top.sv
module dhc_top #(
  parameter int NSRC   = 8,
  parameter int NHART  = 2,
  parameter int PRIO_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dom_en,
  input  logic [NSRC-1:0]     src_en,
  input  logic [NSRC-1:0]     src_pend,
  input  logic [NSRC-1:0]     src_level,
  input  logic [3*NSRC-1:0]   src_mode,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [15:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NSRC-1:0]     pend_clr,
  output logic [NSRC-1:0]     pend_set,
  output logic [NHART-1:0]    irq_o
);
  import dhc_pkg::*;

  localparam logic [4:0] OFF_DELIV = 5'h00;
  localparam logic [4:0] OFF_FORCE = 5'h04;
  localparam logic [4:0] OFF_THR   = 5'h08;
  localparam logic [4:0] OFF_TOP   = 5'h18;
  localparam logic [4:0] OFF_CLAIM = 5'h1C;

  logic [NSRC*32-1:0]     tgt_flat;
  logic [NSRC*14-1:0]     hart_f;
  logic [NSRC*PRIO_W-1:0] prio_f;
  logic                   is_tgt, in_win;
  logic [4:0]             off;
  logic [31:0]            rd_val;

  assign is_tgt = (bus_addr[15:12] == 4'h3) && (bus_addr[1:0] == 2'b00);
  assign in_win = (bus_addr[15:14] == 2'b01);
  assign off    = bus_addr[4:0];

  dhc_targets #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_tgt (
    .clk(clk), .rst_n(rst_n), .we(bus_wr && is_tgt), .widx(bus_addr[11:2]),
    .wdata(bus_wdata), .tgt_flat(tgt_flat));

  for (genvar s = 0; s < NSRC; s++) begin : g_fld
    assign hart_f[s*14 +: 14]         = tgt_flat[s*32 + HIDX_LO +: HIDX_W];
    assign prio_f[s*PRIO_W +: PRIO_W] = tgt_flat[s*32 +: PRIO_W];
  end

  logic [31:0]       top_w   [NHART];
  logic [9:0]        win_w   [NHART];
  logic [NHART-1:0]  sel_h, claim_h, deliv_w, force_w;
  logic [PRIO_W-1:0] thr_w   [NHART];

  for (genvar h = 0; h < NHART; h++) begin : g_hart
    assign sel_h[h]   = in_win && (bus_addr[13:5] == 9'(h));
    assign claim_h[h] = bus_rd && sel_h[h] && (off == OFF_CLAIM);

    dhc_select #(.NSRC(NSRC), .PRIO_W(PRIO_W), .HART(h)) u_sel (
      .en(src_en), .pend(src_pend), .hart_f(hart_f), .prio_f(prio_f),
      .thr(thr_w[h]), .top(top_w[h]), .win_id(win_w[h]));

    dhc_hart_ctl #(.PRIO_W(PRIO_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .dom_en(dom_en),
      .we_deliv(bus_wr && sel_h[h] && off == OFF_DELIV),
      .we_force(bus_wr && sel_h[h] && off == OFF_FORCE),
      .we_thr(bus_wr && sel_h[h] && off == OFF_THR),
      .wdata(bus_wdata), .claim_empty(claim_h[h] && top_w[h] == 32'd0),
      .top_nz(top_w[h] != 32'd0), .deliv_q(deliv_w[h]), .force_q(force_w[h]),
      .thr_q(thr_w[h]), .irq(irq_o[h]));

    p_top_thr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (top_w[h] != 32'd0 && thr_w[h] != '0) |-> (top_w[h][PRIO_W-1:0] < thr_w[h]));
    p_top_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (top_w[h] != 32'd0) |-> (src_en[win_w[h]-10'd1] && src_pend[win_w[h]-10'd1]));
  end

  // claim side effects, active during the read cycle
  always_comb begin
    pend_clr = '0;
    pend_set = '0;
    for (int h = 0; h < NHART; h++) begin
      for (int s = 0; s < NSRC; s++) begin
        if (claim_h[h] && top_w[h] != 32'd0 && win_w[h] == 10'(s + 1)) begin
          pend_clr[s] = 1'b1;
          pend_set[s] = level_active(src_mode[3*s +: 3], src_level[s]);
        end
      end
    end
  end

  always_comb begin
    rd_val = 32'd0;
    for (int s = 0; s < NSRC; s++)
      if (is_tgt && bus_addr[11:2] == 10'(s + 1)) rd_val = tgt_flat[s*32 +: 32];
    for (int h = 0; h < NHART; h++) begin
      if (sel_h[h]) begin
        case (off)
          OFF_DELIV: rd_val = {31'd0, deliv_w[h]};
          OFF_FORCE: rd_val = {31'd0, force_w[h]};
          OFF_THR:   rd_val = 32'(thr_w[h]);
          OFF_TOP, OFF_CLAIM: rd_val = top_w[h];
          default:   rd_val = 32'd0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= 32'd0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  p_clr_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pend_clr));
  p_set_in_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set & ~pend_clr) == '0);
endmodule

// File: tb/tb_dhc_top.sv
`timescale 1ns/1ps
module tb_dhc_top;
  localparam int NSRC = 8, NHART = 2, PRIO_W = 3;

  logic clk = 0, rst_n = 0, dom_en = 0;
  logic [NSRC-1:0] src_en = '0, src_pend = '0, src_level = '0;
  logic [3*NSRC-1:0] src_mode = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NSRC-1:0] pend_clr, pend_set;
  logic [NHART-1:0] irq_o;

  int errors = 0, checks = 0;
  bit done = 0;
  logic rd_d = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  dhc_top #(.NSRC(NSRC), .NHART(NHART), .PRIO_W(PRIO_W)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare read data the cycle after each read
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) if (rd_d && exp_q.size() > 0)
    chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag,
                    input logic [NSRC-1:0] eclr, input logic [NSRC-1:0] eset);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    #1;
    chk({tag, " clr"}, 32'(pend_clr), 32'(eclr));
    chk({tag, " set"}, 32'(pend_set), 32'(eset));
    @(negedge clk); bus_rd = 0;
    src_pend = (src_pend & ~pend_clr) | pend_set;
  endtask

  function automatic logic [15:0] ta(input int s); return 16'(16'h3000 + 4*s); endfunction
  function automatic logic [15:0] ha(input int h, input int o); return 16'(16'h4000 + 32*h + o); endfunction
  function automatic logic [31:0] topv(input int s, input int p); return (32'(s) << 16) | 32'(p); endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("reset irq R8", 32'(irq_o), 0);
    rd(ta(3), 32'h1, "reset target R1", 0, 0);
    rd(ha(0, 'h18), 0, "reset top R4", 0, 0);
    rd(ha(0, 0), 0, "reset deliv R9", 0, 0);
    // R1 priority fix-up
    wr(ta(3), 32'h0);            rd(ta(3), 32'h1, "prio0 R1", 0, 0);
    wr(ta(6), 32'h0004_0008);    rd(ta(6), 32'h0004_0001, "masked prio R1", 0, 0);
    wr(ta(4), 32'h0004_0001);    rd(ta(4), 32'h0004_0001, "hart field R1", 0, 0);
    wr(ta(1), 4); wr(ta(2), 2); wr(ta(3), 2); wr(ta(5), 6);
    // R9 widths
    wr(ha(0, 8), 32'hFF);        rd(ha(0, 8), 7, "thr mask R9", 0, 0);
    wr(ha(0, 0), 3);             rd(ha(0, 0), 1, "deliv bit R9", 0, 0);
    // R2 selection
    src_en = 8'hFF; src_pend = 8'h0F;
    rd(ha(0, 'h18), topv(2, 2), "tie low id R2", 0, 0);
    rd(ha(1, 'h18), topv(4, 1), "hart match R2", 0, 0);
    src_en = 8'hFD;
    rd(ha(0, 'h18), topv(3, 2), "disabled skip R2", 0, 0);
    // R3 threshold
    wr(ha(0, 8), 2);             rd(ha(0, 'h18), 0, "thr excl R3", 0, 0);
    wr(ha(0, 8), 5);             rd(ha(0, 'h18), topv(3, 2), "thr pass R3", 0, 0);
    wr(ha(0, 8), 0);             rd(ha(0, 'h18), topv(3, 2), "thr zero R3", 0, 0);
    // R8 irq gating and latency
    dom_en = 1;
    @(negedge clk); @(negedge clk);
    chk("irq on R8", 32'(irq_o), 32'b01);
    dom_en = 0; #1;
    chk("irq latency R8", 32'(irq_o), 32'b01);
    @(negedge clk);
    chk("irq dom off R8", 32'(irq_o), 0);
    dom_en = 1;
    // R5/R6 claims
    src_mode[3*2 +: 3] = 3'd4;
    rd(ha(0, 'h1C), topv(3, 2), "claim edge R5", 8'h04, 8'h00);
    src_mode[0 +: 3] = 3'd6; src_level[0] = 1;
    rd(ha(0, 'h1C), topv(1, 4), "claim lvl hi R6", 8'h01, 8'h01);
    src_pend[0] = 0; src_pend[4] = 1;
    src_mode[3*4 +: 3] = 3'd7; src_level[4] = 0;
    rd(ha(0, 'h1C), topv(5, 6), "claim lvl lo R6", 8'h10, 8'h10);
    src_mode[3*4 +: 3] = 3'd6;
    rd(ha(0, 'h1C), topv(5, 6), "claim lvl inactive R6", 8'h10, 8'h00);
    rd(ha(0, 'h18), 0, "empty top R4", 0, 0);
    // R7 force
    wr(ha(1, 4), 32'hFFFF_FFFF); wr(ha(1, 0), 1);
    src_pend[3] = 0;
    @(negedge clk);
    chk("force irq R8", 32'(irq_o), 32'b10);
    rd(ha(1, 'h1C), 0, "empty claim R7", 0, 0);
    rd(ha(1, 4), 0, "force cleared R7", 0, 0);
    chk("irq after force clr R7", 32'(irq_o), 0);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule